// File: doc/BRIEF.md
# Pseudo-Static Memory Bus Controller

This block sits between a synchronous system request port and an asynchronous 512K x 8 pseudo-static memory. Each accepted request is a single byte read or write. The block turns it into the memory's three active-low strobes: select, output enable and write enable. It also drives a 19-bit address and controls which way the shared 8-bit data bus points. The data pins are split into an output, an output-enable and an input, and the pad ring joins them into one bidirectional bus.

Every timing minimum of the memory is converted into a whole number of clock cycles, rounded up. Two parameters set this conversion: the clock period in nanoseconds and the speed grade, given as the read cycle time in nanoseconds. The block keeps the write driver away from the bus until the memory has had time to release it after a read.

The memory refreshes itself internally, but only when it is deselected often enough. The block therefore watches how long it has been since select was last held high for a full read cycle time. When that time approaches the hold-off window (15 µs by default), the block stops accepting requests. It stalls new requests until select has been high for one full read cycle time, and then resumes.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is held and directly after it, select, output enable and write enable are high, the data driver is off, no read response is signalled and a request is accepted.
- R2: A read holds select low, output enable low and write enable high for RC = ceil(grade / clock period) cycles. The data bus is sampled on the last of those cycles, and the sampled byte is returned with a single-cycle response valid in the next cycle.
- R3: A write holds write enable low for WP cycles. WP = ceil of the largest of three times: the write pulse width (40 ns, 45 ns for the 70 ns grade), select-to-write-end (45 ns, 55 ns for the 70 ns grade) and the 25 ns data setup time. Select and address then stay put for max(1, RC - WP) more cycles with write enable high.
- R4: The block drives the data bus only while select is low, write enable is low and output enable is high, and it drives the request's byte throughout that time.
- R5: Write enable never falls until output enable has been high for at least HZ = ceil(25 ns / clock period) consecutive cycles. Extra setup cycles are inserted, with select low and both enables high, when this is not yet so.
- R6: A request is accepted in the cycle where request valid and ready are both high. Ready is high only while the bus is idle (all strobes high), and select goes high for at least one cycle between accesses.
- R7: When the time since select was last high for RC consecutive cycles reaches a trigger point, ready stays low until select has been high for RC consecutive cycles. The trigger point is set so that the hold-off window is never exceeded.
- R8: Output enable and write enable are never low together.
- R9: The address is stable in every cycle in which select stays low from the previous cycle.
- R10: A request that arrives while a refresh gap is being forced is held off for the whole gap, which lasts RC cycles, and is then accepted unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request taken this cycle when valid is high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle pulse with read data |
| rsp_rdata_o | output | 8 | Read byte |
| mem_ce_n_o | output | 1 | Memory select, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_addr_o | output | 19 | Memory address |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Data driver enable toward the memory |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
Isolated writes followed by read-back at the lowest, highest and scattered addresses separate correct strobe lengths and capture timing from off-by-one counts. The bench memory model presents valid data only in the last cycle of a read, so early capture returns a wrong byte. Running a read straight into a write exposes the bus release guard: the setup cycles appear only after output enable has recently been high. A long unbroken stream of back-to-back reads runs past the refresh trigger and shows whether the forced gap appears, how long it lasts and whether the stalled request then goes through intact.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_READ,
    SQ_WSET,
    SQ_WLOW,
    SQ_WREC
  } seq_st_e;

  localparam int DSETUP_NS  = 25;
  localparam int RELEASE_NS = 25;

  function automatic int ceil_div(int n, int d);
    return (n + d - 1) / d;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int wpulse_ns(int grade_ns);
    return (grade_ns >= 70) ? 45 : 40;
  endfunction

  // select-low and address-setup to write end share one value
  function automatic int ce_end_ns(int grade_ns);
    return (grade_ns >= 70) ? 55 : 45;
  endfunction

  function automatic int rc_cyc(int clk_ns, int grade_ns);
    return ceil_div(grade_ns, clk_ns);
  endfunction

  function automatic int wp_cyc(int clk_ns, int grade_ns);
    return imax(ceil_div(wpulse_ns(grade_ns), clk_ns),
                imax(ceil_div(ce_end_ns(grade_ns), clk_ns), ceil_div(DSETUP_NS, clk_ns)));
  endfunction

  function automatic int rec_cyc(int clk_ns, int grade_ns);
    return imax(1, rc_cyc(clk_ns, grade_ns) - wp_cyc(clk_ns, grade_ns));
  endfunction

  function automatic int hz_cyc(int clk_ns);
    return ceil_div(RELEASE_NS, clk_ns);
  endfunction

  function automatic int win_cyc(int clk_ns, int window_ns);
    return window_ns / clk_ns;
  endfunction

  // latest window count at which a new access may still start
  function automatic int trig_cyc(int clk_ns, int grade_ns, int window_ns);
    int longest;
    longest = imax(rc_cyc(clk_ns, grade_ns),
                   hz_cyc(clk_ns) + wp_cyc(clk_ns, grade_ns) + rec_cyc(clk_ns, grade_ns));
    return win_cyc(clk_ns, window_ns) - rc_cyc(clk_ns, grade_ns) - longest - 1;
  endfunction

endpackage

// File: rtl/psram_bus_turn.sv
module psram_bus_turn #(
  parameter int HZ_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_n_i,
  output logic turn_ok_o
);
  localparam int GW = $clog2(HZ_CYC + 1);
  localparam logic [GW-1:0] GMAX = GW'(HZ_CYC);

  logic [GW-1:0] gap_q, gap_d;

  // count of OE-high cycles including the current one
  always_comb begin
    if (!oe_n_i)           gap_d = '0;
    else if (gap_q == GMAX) gap_d = gap_q;
    else                   gap_d = gap_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= GMAX;
    else         gap_q <= gap_d;
  end

  assign turn_ok_o = (gap_d == GMAX);
endmodule

// File: rtl/psram_refresh_guard.sv
module psram_refresh_guard #(
  parameter int RC_CYC   = 6,
  parameter int TRIG_CYC = 1484
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_i,
  output logic due_o
);
  localparam int RW = $clog2(RC_CYC + 1);
  localparam int WW = $clog2(TRIG_CYC + 1);
  localparam logic [RW-1:0] RMAX = RW'(RC_CYC);
  localparam logic [WW-1:0] WMAX = WW'(TRIG_CYC);

  logic [RW-1:0] run_q, run_d;
  logic [WW-1:0] win_q, win_d;

  always_comb begin
    if (!ce_n_i)            run_d = '0;
    else if (run_q == RMAX) run_d = run_q;
    else                    run_d = run_q + 1'b1;

    if (run_d == RMAX)      win_d = '0;
    else if (win_q == WMAX) win_d = win_q;
    else                    win_d = win_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      win_q <= '0;
    end else begin
      run_q <= run_d;
      win_q <= win_d;
    end
  end

  assign due_o = (win_q == WMAX);
endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_ctrl_pkg::*;
#(
  parameter int AW      = 19,
  parameter int DW      = 8,
  parameter int RC_CYC  = 6,
  parameter int WP_CYC  = 5,
  parameter int REC_CYC = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_ready_o,
  input  logic          due_i,
  input  logic          turn_ok_i,
  input  logic [DW-1:0] dq_i,
  output logic          ce_n_o,
  output logic          oe_n_o,
  output logic          we_n_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);
  localparam int CMAX = imax(RC_CYC, imax(WP_CYC, REC_CYC));
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] RC_LD  = CW'(RC_CYC - 1);
  localparam logic [CW-1:0] WP_LD  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] REC_LD = CW'(REC_CYC - 1);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          take, rd_last;
  logic          ce_n_q, oe_n_q, we_n_q, dq_oe_q, rsp_v_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rsp_d_q;

  assign req_ready_o = (st_q == SQ_IDLE) && !due_i;
  assign take        = req_valid_i && req_ready_o;
  assign rd_last     = (st_q == SQ_READ) && (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
    unique case (st_q)
      SQ_IDLE: begin
        if (take) begin
          if (!req_write_i) begin
            st_d  = SQ_READ;
            cnt_d = RC_LD;
          end else if (turn_ok_i) begin
            st_d  = SQ_WLOW;
            cnt_d = WP_LD;
          end else begin
            st_d = SQ_WSET;
          end
        end
      end
      SQ_READ: if (cnt_q == '0) st_d = SQ_IDLE;
      SQ_WSET: begin
        if (turn_ok_i) begin
          st_d  = SQ_WLOW;
          cnt_d = WP_LD;
        end
      end
      SQ_WLOW: begin
        if (cnt_q == '0) begin
          st_d  = SQ_WREC;
          cnt_d = REC_LD;
        end
      end
      SQ_WREC: if (cnt_q == '0) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  // strobes are registered from the next state so the pins stay glitch free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      cnt_q   <= '0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ce_n_q  <= (st_d == SQ_IDLE);
      oe_n_q  <= (st_d != SQ_READ);
      we_n_q  <= (st_d != SQ_WLOW);
      dq_oe_q <= (st_d == SQ_WLOW);
      if (take) begin
        addr_q <= req_addr_i;
        data_q <= req_wdata_i;
      end
      rsp_v_q <= rd_last;
      if (rd_last) rsp_d_q <= dq_i;
    end
  end

  assign ce_n_o      = ce_n_q;
  assign oe_n_o      = oe_n_q;
  assign we_n_o      = we_n_q;
  assign addr_o      = addr_q;
  assign dq_o        = data_q;
  assign dq_oe_o     = dq_oe_q;
  assign rsp_valid_o = rsp_v_q;
  assign rsp_rdata_o = rsp_d_q;
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int GRADE_NS  = 55,
  parameter int WINDOW_NS = 15000,
  parameter int AW        = 19,
  parameter int DW        = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mem_ce_n_o,
  output logic          mem_oe_n_o,
  output logic          mem_we_n_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int RC_CYC   = rc_cyc(CLK_NS, GRADE_NS);
  localparam int WP_CYC   = wp_cyc(CLK_NS, GRADE_NS);
  localparam int REC_CYC  = rec_cyc(CLK_NS, GRADE_NS);
  localparam int HZ_CYC   = hz_cyc(CLK_NS);
  localparam int TRIG_CYC = trig_cyc(CLK_NS, GRADE_NS, WINDOW_NS);

  logic due, turn_ok;

  psram_refresh_guard #(
    .RC_CYC  (RC_CYC),
    .TRIG_CYC(TRIG_CYC)
  ) u_guard (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_n_i(mem_ce_n_o),
    .due_o (due)
  );

  if (HZ_CYC > 0) begin : g_turn
    psram_bus_turn #(
      .HZ_CYC(HZ_CYC)
    ) u_turn (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .oe_n_i   (mem_oe_n_o),
      .turn_ok_o(turn_ok)
    );
  end else begin : g_no_turn
    assign turn_ok = 1'b1;
  end

  psram_seq #(
    .AW     (AW),
    .DW     (DW),
    .RC_CYC (RC_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .req_ready_o(req_ready_o),
    .due_i      (due),
    .turn_ok_i  (turn_ok),
    .dq_i       (mem_dq_i),
    .ce_n_o     (mem_ce_n_o),
    .oe_n_o     (mem_oe_n_o),
    .we_n_o     (mem_we_n_o),
    .addr_o     (mem_addr_o),
    .dq_o       (mem_dq_o),
    .dq_oe_o    (mem_dq_oe_o),
    .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o)
  );
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk
  import psram_ctrl_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int GRADE_NS  = 55,
  parameter int WINDOW_NS = 15000,
  parameter int AW        = 19
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic          mem_ce_n_o,
  input logic          mem_oe_n_o,
  input logic          mem_we_n_o,
  input logic          mem_dq_oe_o,
  input logic [AW-1:0] mem_addr_o
);
  localparam int RC  = rc_cyc(CLK_NS, GRADE_NS);
  localparam int WP  = wp_cyc(CLK_NS, GRADE_NS);
  localparam int HZ  = hz_cyc(CLK_NS);
  localparam int WIN = win_cyc(CLK_NS, WINDOW_NS);

  int oe_hi, oe_lo, we_lo, ce_hi, win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_hi <= HZ;
      oe_lo <= 0;
      we_lo <= 0;
      ce_hi <= 0;
      win   <= 0;
    end else begin
      oe_hi <= mem_oe_n_o ? ((oe_hi < HZ) ? oe_hi + 1 : oe_hi) : 0;
      oe_lo <= !mem_oe_n_o ? ((oe_lo < RC + 1) ? oe_lo + 1 : oe_lo) : 0;
      we_lo <= !mem_we_n_o ? ((we_lo < WP + 1) ? we_lo + 1 : we_lo) : 0;
      ce_hi <= mem_ce_n_o ? ((ce_hi < RC) ? ce_hi + 1 : ce_hi) : 0;
      if (mem_ce_n_o && ce_hi >= RC - 1) win <= 0;
      else if (win < WIN + 1)            win <= win + 1;
    end
  end

  a_r8_no_double_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_n_o && !mem_we_n_o));

  a_r4_drive_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (!mem_we_n_o && mem_oe_n_o && !mem_ce_n_o));

  a_r9_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_n_o && $past(!mem_ce_n_o)) |-> $stable(mem_addr_o));

  a_r2_rsp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r2_read_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_n_o) |-> (oe_lo == RC));

  a_r3_we_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_lo == WP));

  a_r5_bus_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_n_o) |-> (oe_hi >= HZ));

  a_r6_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_n_o && mem_oe_n_o && mem_we_n_o));

  a_r7_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win < WIN);
endmodule

bind psram_ctrl psram_ctrl_chk #(
  .CLK_NS   (CLK_NS),
  .GRADE_NS (GRADE_NS),
  .WINDOW_NS(WINDOW_NS),
  .AW       (AW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .mem_ce_n_o (mem_ce_n_o),
  .mem_oe_n_o (mem_oe_n_o),
  .mem_we_n_o (mem_we_n_o),
  .mem_dq_oe_o(mem_dq_oe_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/psram_ctrl_bench.sv
`timescale 1ns/1ps
module psram_ctrl_bench;
  // expected cycle counts at 10 ns clock, 55 ns grade, 15 us window
  localparam int B_RC   = (55 + 9) / 10;
  localparam int B_WP   = 5;            // max of 40, 45, 25 ns -> 4, 5, 3
  localparam int B_REC  = 1;
  localparam int B_HZ   = 3;
  localparam int B_TRIG = 15000 / 10 - B_RC - (B_HZ + B_WP + B_REC) - 1;

  localparam int K_IDLE = 0, K_RD = 1, K_WSET = 2, K_WLOW = 3, K_WREC = 4;

  typedef struct {
    int        kind;
    bit        ce_n, oe_n, we_n, drv, last_rd, rsp;
    bit [18:0] a;
    bit [7:0]  d, rd;
  } ent_t;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        ce_n, oe_n, we_n, dq_oe;
  logic [18:0] m_addr;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i = 8'hEE;

  always #5 clk = ~clk;

  psram_ctrl u_psram_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
    .mem_addr_o(m_addr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0, run_cmp = 0;
  bit [7:0] mem [int];

  function automatic bit [7:0] memval(bit [18:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : (a[7:0] ^ 8'hA5);
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic ent_t mk(int kind, bit [18:0] a, bit [7:0] d);
    ent_t e;
    e.kind = kind; e.a = a; e.d = d; e.last_rd = 0; e.rsp = 0; e.rd = '0;
    e.ce_n = (kind == K_IDLE);
    e.oe_n = (kind != K_RD);
    e.we_n = (kind != K_WLOW);
    e.drv  = (kind == K_WLOW);
    return e;
  endfunction

  // reference model: timeline of expected pin states, advanced per clock
  ent_t cur, q[$];
  int   oe_hi_m, ce_hi_m, since_gap;
  bit [18:0] last_a;
  bit   m_ready;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      last_a = '0;
      cur = mk(K_IDLE, '0, '0);
      oe_hi_m = B_HZ; ce_hi_m = 0; since_gap = 0;
      m_ready = 1;
    end else begin
      bit accept, was_last;
      accept   = m_ready && req_valid;
      was_last = cur.last_rd;
      if (cur.oe_n) oe_hi_m = (oe_hi_m < B_HZ) ? oe_hi_m + 1 : oe_hi_m; else oe_hi_m = 0;
      if (cur.ce_n) ce_hi_m = (ce_hi_m < B_RC) ? ce_hi_m + 1 : ce_hi_m; else ce_hi_m = 0;
      since_gap = (ce_hi_m == B_RC) ? 0 : since_gap + 1;
      if (q.size() == 0 && accept) begin
        last_a = req_addr;
        if (!req_write) begin
          for (int i = 0; i < B_RC; i++) q.push_back(mk(K_RD, req_addr, req_wdata));
          q[B_RC-1].last_rd = 1;
        end else begin
          for (int i = 0; i < B_HZ - oe_hi_m; i++) q.push_back(mk(K_WSET, req_addr, req_wdata));
          for (int i = 0; i < B_WP; i++) q.push_back(mk(K_WLOW, req_addr, req_wdata));
          for (int i = 0; i < B_REC; i++) q.push_back(mk(K_WREC, req_addr, req_wdata));
        end
      end
      if (q.size() != 0) cur = q.pop_front();
      else cur = mk(K_IDLE, last_a, '0);
      if (was_last) begin
        cur.rsp = 1;
        cur.rd  = memval(last_a);
      end
      m_ready = (cur.kind == K_IDLE) && (since_gap < B_TRIG);
    end
  end

  // per-cycle comparison and bench memory, away from the active edge
  bit        p_we_n = 1, p_rd = 0;
  bit [18:0] p_addr;
  bit [7:0]  p_dq;
  int        rd_idx = 0, stall = 0, max_stall = 0, gaps = 0;

  always @(negedge clk) begin
    if (rst_n && run_cmp && !done) begin
      string st_tag;
      case (cur.kind)
        K_IDLE:  st_tag = "R6";
        K_RD:    st_tag = "R2";
        K_WSET:  st_tag = "R5";
        default: st_tag = "R3";
      endcase
      chk(st_tag, "ce_n", ce_n, cur.ce_n);
      chk(st_tag, "oe_n", oe_n, cur.oe_n);
      chk(st_tag, "we_n", we_n, cur.we_n);
      chk("R4", "dq_oe", dq_oe, cur.drv);
      if (cur.drv) chk("R4", "dq_o", dq_o, cur.d);
      chk("R9", "addr", m_addr, cur.a);
      chk((since_gap >= B_TRIG) ? "R7" : "R6", "ready", req_ready, m_ready);
      chk("R2", "rsp_valid", rsp_valid, cur.rsp);
      if (cur.rsp) chk("R2", "rsp_rdata", rsp_rdata, cur.rd);
      chk("R8", "oe_we_both_low", (!oe_n && !we_n), 0);
      // write commits on WE rising
      if (!p_we_n && we_n) mem[int'(p_addr)] = p_dq;
      // gap tracking for R10
      if (req_valid && !req_ready && ce_n) begin
        stall++;
        if (stall == 1) gaps++;
        if (stall > max_stall) max_stall = stall;
      end else stall = 0;
    end
    // memory output: valid only in the final cycle of a full-length read
    if (!ce_n && !oe_n && we_n) begin
      rd_idx = (p_rd && m_addr == p_addr) ? rd_idx + 1 : 0;
      p_rd = 1;
    end else begin
      rd_idx = 0;
      p_rd = 0;
    end
    dq_i  = (p_rd && rd_idx >= B_RC - 1) ? memval(m_addr) : 8'hEE;
    p_we_n = we_n;
    p_addr = m_addr;
    p_dq   = dq_o;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic issue(bit w, bit [18:0] a, bit [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    for (int t = 0; t < 400; t++) begin
      if (req_ready) begin
        @(posedge clk);
        return;
      end
      @(negedge clk);
    end
    chk("R6", "request_accepted", 0, 1);
  endtask

  task automatic release_req();
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic rd_expect(bit [18:0] a, bit [7:0] exp);
    bit seen = 0;
    issue(0, a, 8'h00);
    release_req();
    for (int t = 0; t < 30 && !seen; t++) begin
      if (rsp_valid) begin
        seen = 1;
        chk("R2", "readback", rsp_rdata, exp);
      end else @(negedge clk);
    end
    if (!seen) chk("R2", "rsp_seen", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk("R1", "ce_n_rst", ce_n, 1);
    chk("R1", "oe_n_rst", oe_n, 1);
    chk("R1", "we_n_rst", we_n, 1);
    chk("R1", "dq_oe_rst", dq_oe, 0);
    chk("R1", "rsp_rst", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "ready_after_rst", req_ready, 1);
    run_cmp = 1;

    // R3: writes at edges and scattered addresses, back to back
    issue(1, 19'h00000, 8'h3C);
    issue(1, 19'h7FFFF, 8'hC3);
    issue(1, 19'h12345, 8'h5A);
    issue(1, 19'h00001, 8'hFF);
    release_req();
    repeat (3) @(negedge clk);

    // R2: read back
    rd_expect(19'h00000, 8'h3C);
    rd_expect(19'h7FFFF, 8'hC3);
    rd_expect(19'h12345, 8'h5A);
    rd_expect(19'h00001, 8'hFF);
    rd_expect(19'h4ABCD, 8'hCD ^ 8'hA5);

    // R5: read straight into write, then read back the new value
    issue(0, 19'h12345, 8'h00);
    issue(1, 19'h12345, 8'h81);
    issue(0, 19'h12345, 8'h00);
    release_req();
    repeat (10) @(negedge clk);
    rd_expect(19'h12345, 8'h81);

    // R7 / R10: unbroken read stream past the refresh trigger
    for (int i = 0; i < 260; i++) issue(0, 19'((i * 37) & 19'h7FFFF), 8'h00);
    release_req();
    repeat (20) @(negedge clk);
    chk("R7", "gaps_forced", (gaps >= 1), 1);
    chk("R10", "stall_length", max_stall, B_RC);
    rd_expect(19'h7FFFF, 8'hC3);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule